// File: doc/BRIEF.md
# Event Counter with Coherent Snapshot Readout

The block counts events in both directions. Each clock in which the enable input is high moves a 24-bit count by one, up when the direction input is high and down when it is low. The count wraps modulo 2^24. Two wrap flags record crossings of the zero boundary. The up-flag toggles each time the count rolls from all ones to zero. The down-flag toggles each time the count rolls from zero to all ones. The XOR of the two flags is a 25th bit, which extends the count into a signed 25-bit value.

Software reaches the block through a small synchronous port. A write to the count address presets the count and clears both flags. A write to the capture address copies the count and both flags into shadow registers on a single clock edge. All reads return shadow values only. Count, flags and the 25-bit view therefore always describe the same moment, even when several reads are separated in time while the counter keeps moving.

Each clock the core picks one operation from an enumerated set. OP_LOAD is taken on a preset write. OP_UP is taken on an enabled up step. OP_DOWN is taken on an enabled down step. OP_HOLD covers everything else. OP_LOAD wins over OP_UP and OP_DOWN. OP_UP flips the up-flag when the count is all ones. OP_DOWN flips the down-flag when the count is zero. OP_HOLD leaves every register unchanged.

Top module: `evt_snap_counter`

## Requirements
- R1: A synchronous active-high reset clears the count, both flags and all shadow registers to zero, so every read address returns 0 afterwards.
- R2: When the enable is high and no preset is written, the count increases by one modulo 2^24 if the direction is 1 and decreases by one if it is 0. When the enable is low, the count and flags are unchanged.
- R3: An up step from 0xFFFFFF to 0 toggles the up-flag, and the down-flag is unchanged.
- R4: A down step from 0 to 0xFFFFFF toggles the down-flag, and the up-flag is unchanged.
- R5: A write to address 0 loads the written value into the count and clears both flags in the same cycle. This takes priority over a count step in that cycle.
- R6: A write to address 3 copies the count and both flags, as they were before that clock edge, into the shadow registers. Reads keep returning those shadow values until the next such write, however the live count moves.
- R7: Reads are combinational from the shadows. Address 0 returns {0, count}. Address 1 returns the up-flag in bit 0 and the down-flag in bit 1, with zero elsewhere. Address 2 returns {up-flag XOR down-flag, count}. Address 3 returns 0.
- R8: Writes to addresses 1 and 2 change neither the count, the flags nor the shadows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cnt_en | input | 1 | Count enable, one step per clock |
| cnt_up | input | 1 | Direction: 1 up, 0 down |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 preset, 3 capture) |
| wr_data | input | 24 | Preset value |
| rd_addr | input | 2 | Read address |
| rd_data | output | 25 | Read data from the shadow registers |

## Verification
The hardest case to reach is a count that crosses zero in both directions between two captures. In that case each flag toggles repeatedly while the count ends up near zero. The bench presets the count to 0xFFFFFF and steps it up, down and up across the boundary. It captures between the steps and also runs long stretches without a capture, so that reads must stay frozen at an older state. A constrained random phase then mixes presets near the wrap points, captures, ignored writes and direction changes. In that phase a capture and a preset often land in the same cycle as a step.

// File: rtl/evt_cnt_pkg.sv
`timescale 1ns/1ps
package evt_cnt_pkg;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_COUNT = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 2'd1;
    localparam logic [ADDR_W-1:0] ADDR_WIDE  = 2'd2;
    localparam logic [ADDR_W-1:0] ADDR_SNAP  = 2'd3;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_UP   = 2'd1,
        OP_DOWN = 2'd2,
        OP_LOAD = 2'd3
    } cnt_op_e;
endpackage

// File: rtl/evt_cnt_core.sv
`timescale 1ns/1ps
module evt_cnt_core
    import evt_cnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         cnt_up,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt_q,
    output logic         upf_q,
    output logic         dnf_q
);
    localparam logic [W-1:0] ONE = W'(1);

    cnt_op_e      op;
    logic [W-1:0] cnt_d;
    logic         upf_d;
    logic         dnf_d;
    logic         at_max;
    logic         at_zero;

    assign at_max  = &cnt_q;
    assign at_zero = ~|cnt_q;

    // operation select: preset outranks a step
    always_comb begin
        if (load)
            op = OP_LOAD;
        else if (cnt_en && cnt_up)
            op = OP_UP;
        else if (cnt_en)
            op = OP_DOWN;
        else
            op = OP_HOLD;
    end

    // next-value process
    always_comb begin
        cnt_d = cnt_q;
        upf_d = upf_q;
        dnf_d = dnf_q;
        unique case (op)
            OP_LOAD: begin
                cnt_d = load_val;
                upf_d = 1'b0;
                dnf_d = 1'b0;
            end
            OP_UP: begin
                cnt_d = cnt_q + ONE;
                if (at_max) upf_d = ~upf_q;
            end
            OP_DOWN: begin
                cnt_d = cnt_q - ONE;
                if (at_zero) dnf_d = ~dnf_q;
            end
            OP_HOLD: ;
            default: ;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            upf_q <= 1'b0;
            dnf_q <= 1'b0;
        end else begin
            cnt_q <= cnt_d;
            upf_q <= upf_d;
            dnf_q <= dnf_d;
        end
    end

    // R2
    up_step_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_up && !load) |=> (cnt_q == $past(cnt_q) + ONE));
    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!cnt_en && !load) |=> ($stable(cnt_q) && $stable(upf_q) && $stable(dnf_q)));
    // R3
    up_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && cnt_up && !load && (&cnt_q))
        |=> ((cnt_q == '0) && (upf_q != $past(upf_q)) && $stable(dnf_q)));
    // R4
    down_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (cnt_en && !cnt_up && !load && (cnt_q == '0))
        |=> ((&cnt_q) && (dnf_q != $past(dnf_q)) && $stable(upf_q)));
    // R5
    preset_load_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> ((cnt_q == $past(load_val)) && !upf_q && !dnf_q));
endmodule

// File: rtl/evt_cnt_shadow.sv
`timescale 1ns/1ps
module evt_cnt_shadow #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         capture,
    input  logic [W-1:0] live_cnt,
    input  logic         live_upf,
    input  logic         live_dnf,
    output logic [W-1:0] shd_cnt,
    output logic         shd_upf,
    output logic         shd_dnf
);
    always_ff @(posedge clk) begin
        if (rst) begin
            shd_cnt <= '0;
            shd_upf <= 1'b0;
            shd_dnf <= 1'b0;
        end else if (capture) begin
            shd_cnt <= live_cnt;
            shd_upf <= live_upf;
            shd_dnf <= live_dnf;
        end
    end

    // R6
    capture_coherent_chk: assert property (@(posedge clk) disable iff (rst)
        capture |=> ((shd_cnt == $past(live_cnt)) && (shd_upf == $past(live_upf))
                     && (shd_dnf == $past(live_dnf))));
    // R6
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !capture |=> ($stable(shd_cnt) && $stable(shd_upf) && $stable(shd_dnf)));
endmodule

// File: rtl/evt_cnt_rdmux.sv
`timescale 1ns/1ps
module evt_cnt_rdmux
    import evt_cnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [W-1:0]      shd_cnt,
    input  logic              shd_upf,
    input  logic              shd_dnf,
    output logic [W:0]        rd_data
);
    always_comb begin
        unique case (rd_addr)
            ADDR_COUNT: rd_data = {1'b0, shd_cnt};
            ADDR_FLAGS: rd_data = {{(W-1){1'b0}}, shd_dnf, shd_upf};
            ADDR_WIDE:  rd_data = {shd_upf ^ shd_dnf, shd_cnt};
            ADDR_SNAP:  rd_data = '0;
            default:    rd_data = '0;
        endcase
    end
endmodule

// File: rtl/evt_snap_counter.sv
`timescale 1ns/1ps
module evt_snap_counter
    import evt_cnt_pkg::*;
#(
    parameter int W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cnt_en,
    input  logic              cnt_up,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [W-1:0]      wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [W:0]        rd_data
);
    logic         load;
    logic         capture;
    logic [W-1:0] live_cnt;
    logic         live_upf;
    logic         live_dnf;
    logic [W-1:0] shd_cnt;
    logic         shd_upf;
    logic         shd_dnf;

    assign load    = wr_en && (wr_addr == ADDR_COUNT);
    assign capture = wr_en && (wr_addr == ADDR_SNAP);

    evt_cnt_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .load(load), .load_val(wr_data),
        .cnt_q(live_cnt), .upf_q(live_upf), .dnf_q(live_dnf)
    );

    evt_cnt_shadow #(.W(W)) u_shadow (
        .clk(clk), .rst(rst), .capture(capture),
        .live_cnt(live_cnt), .live_upf(live_upf), .live_dnf(live_dnf),
        .shd_cnt(shd_cnt), .shd_upf(shd_upf), .shd_dnf(shd_dnf)
    );

    evt_cnt_rdmux #(.W(W)) u_rdmux (
        .rd_addr(rd_addr), .shd_cnt(shd_cnt), .shd_upf(shd_upf),
        .shd_dnf(shd_dnf), .rd_data(rd_data)
    );

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && (wr_addr == ADDR_FLAGS || wr_addr == ADDR_WIDE) && !cnt_en)
        |=> ($stable(live_cnt) && $stable(live_upf) && $stable(live_dnf) && $stable(shd_cnt)));
endmodule

// File: tb/evt_snap_counter_test.sv
`timescale 1ns/1ps
module evt_snap_counter_test;
    localparam int W = 24;
    localparam logic [W-1:0] MAXV = '1;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic         rst = 1'b1;
    logic         cnt_en = 1'b0;
    logic         cnt_up = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W:0]   rd_data;

    int n_vec = 0;
    int n_bad = 0;

    logic [W-1:0] m_cnt = '0, s_cnt = '0;
    bit m_c = 0, m_b = 0, s_c = 0, s_b = 0;

    evt_snap_counter #(.W(W)) uut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .cnt_up(cnt_up),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic check_reads(input string req);
        logic [W:0] exp;
        for (int a = 0; a < 4; a++) begin
            rd_addr = 2'(a);
            #0.25;
            case (a)
                0: exp = {1'b0, s_cnt};
                1: exp = {{(W-1){1'b0}}, s_b, s_c};
                2: exp = {s_c ^ s_b, s_cnt};
                default: exp = '0;
            endcase
            n_vec++;
            if (rd_data !== exp) begin
                n_bad++;
                $display("FAIL %s addr %0d actual %h expected %h", req, a, rd_data, exp);
            end
        end
    endtask

    task automatic tick(input bit r, input bit en, input bit up, input bit wr,
                        input logic [1:0] wa, input logic [W-1:0] wd, input string req);
        rst = r; cnt_en = en; cnt_up = up; wr_en = wr; wr_addr = wa; wr_data = wd;
        @(posedge clk);
        if (r) begin
            m_cnt = '0; m_c = 0; m_b = 0; s_cnt = '0; s_c = 0; s_b = 0;
        end else begin
            if (wr && wa == 2'd3) begin
                s_cnt = m_cnt; s_c = m_c; s_b = m_b;
            end
            if (wr && wa == 2'd0) begin
                m_cnt = wd; m_c = 0; m_b = 0;
            end else if (en) begin
                if (up) begin
                    if (m_cnt == MAXV) m_c = !m_c;
                    m_cnt = m_cnt + 1'b1;
                end else begin
                    if (m_cnt == '0) m_b = !m_b;
                    m_cnt = m_cnt - 1'b1;
                end
            end
        end
        @(negedge clk);
        rst = 1'b0; cnt_en = 1'b0; wr_en = 1'b0;
        check_reads(req);
    endtask

    task automatic step(input bit up, input string req);
        tick(0, 1, up, 0, 2'd0, '0, req);
    endtask
    task automatic snap(input string req);
        tick(0, 0, 0, 1, 2'd3, '0, req);
    endtask
    task automatic preset(input logic [W-1:0] v, input string req);
        tick(0, 0, 0, 1, 2'd0, v, req);
    endtask

    initial begin
        #800000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick(1, 1, 1, 1, 2'd0, 24'h123456, "R1 reset");
        tick(1, 0, 0, 0, 2'd0, '0, "R1 reset");
        // basic stepping and capture
        for (int i = 0; i < 5; i++) step(1, "R2 up");
        snap("R6 capture");
        for (int i = 0; i < 2; i++) step(0, "R2 down");
        tick(0, 0, 1, 0, 2'd0, '0, "R2 idle");
        snap("R7 readback");
        // up wrap
        preset(24'hFFFFFE, "R5 preset");
        snap("R5 preset visible");
        for (int i = 0; i < 3; i++) step(1, "R3 up wrap");
        snap("R3 carry set");
        // down wrap
        preset(24'h000001, "R5 preset");
        for (int i = 0; i < 3; i++) step(0, "R4 down wrap");
        snap("R4 borrow set");
        // zero straddle with stale shadows
        preset(MAXV, "R5 preset");
        step(1, "R3 straddle");
        snap("R6 straddle capture");
        step(0, "R4 straddle");
        step(1, "R3 straddle");
        for (int i = 0; i < 42; i++) step(1, "R6 shadow frozen");
        step(0, "R6 shadow frozen");
        snap("R7 wide view");
        // ignored writes
        tick(0, 0, 0, 1, 2'd1, 24'hABCDEF, "R8 flags write ignored");
        tick(0, 0, 0, 1, 2'd2, 24'h00FF00, "R8 wide write ignored");
        snap("R8 state intact");
        // preset versus step
        tick(0, 1, 1, 1, 2'd0, MAXV, "R5 preset beats step");
        snap("R5 priority");
        // capture with simultaneous step
        tick(0, 1, 1, 1, 2'd3, '0, "R6 capture with step");
        snap("R6 after step");
        // reset mid-run
        tick(1, 0, 0, 0, 2'd0, '0, "R1 mid-run reset");
        // random mix
        for (int i = 0; i < 600; i++) begin
            int k;
            logic [W-1:0] v;
            k = $urandom_range(0, 15);
            v = ($urandom_range(0, 1) == 1) ? (MAXV - W'($urandom_range(0, 3)))
                                             : W'($urandom_range(0, 3));
            case (k)
                0: tick(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1, 2'd0, v, "R5 random preset");
                1, 2: tick(0, $urandom_range(0, 1) == 1, $urandom_range(0, 1) == 1, 1, 2'd3, '0, "R6 random capture");
                3: tick(0, 0, 0, 1, 2'($urandom_range(1, 2)), v, "R8 random ignored write");
                default: tick(0, $urandom_range(0, 3) != 0, $urandom_range(0, 2) != 0, 0, 2'd0, '0, "R2 random step");
            endcase
        end
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule